// File: doc/BRIEF.md
# Business-Card Grammar Parse Tracker

This block follows a byte stream's progress through a fixed record grammar, one recognised token at a time. A pattern detector upstream raises one pulse per token it sees: an opening or closing tag, one of the two route-key words, or a free-text string. This block takes those pulses, together with a start-of-packet pulse, and keeps one register for each place in the grammar where a token may legally appear. A register is loaded when its own token arrives while one of its grammatical predecessors holds the active position. The predecessor links come from the grammar's FOLLOW relations. Where several predecessors lead into one place, their outputs are ORed.

The record accepted is: card open, key open, the word "first" or "last", key close, name open, then a first-name element and a last-name element in either order, each holding one string, then name close. After that comes an optional title element, an optional phone element, and card close. Downstream routing logic receives a one-cycle-delayed copy of every match bit, paired with the parse position that was active when the match arrived. It also receives a flag that says the whole record was accepted.

Top module: `card_parse_tracker`

## Requirements
- R1: A start-of-packet cycle loads the entry position (state bit 0) and clears every other state bit and `msg_valid` on the next edge. Any match bits present in that same cycle do not move the state.
- R2: `parse_state` never has more than one bit set.
- R3: Match bit numbering is 0 string, 1 card open, 2 card close, 3 key open, 4 key close, 5 word first, 6 word last, 7 name open, 8 name close, 9 first open, 10 first close, 11 last open, 12 last close, 13 title open, 14 title close, 15 phone open, 16 phone close. A cycle with at least one match bit moves the state, on the next edge, to the position that the token reaches from the active position. A cycle with no match bits and no start-of-packet leaves `parse_state` and `msg_valid` unchanged.
- R4: State bit numbering follows the record path. 1 card open, 2 key open, 3 word first, 4 word last, 5 key close, 6 name open. The first-then-last path is 7 first open, 8 string, 9 first close, 10 last open, 11 string, 12 last close. The last-then-first path is 13 last open, 14 string, 15 last close, 16 first open, 17 string, 18 first close. Then 19 name close, 20 title open, 21 string, 22 title close, 23 phone open, 24 string, 25 phone close, 26 card close. Either route-key word is accepted.
- R5: Both name orders are accepted, each along its own state bits.
- R6: Title and phone are each optional, and all four present/absent combinations are accepted.
- R7: A token that is not expected from the active position clears all state bits. The state stays zero until the next start-of-packet, and `msg_valid` does not assert for that packet.
- R8: `msg_valid` rises in the same cycle that state bit 26 becomes set. It then stays high until the next start-of-packet, even if more tokens arrive.
- R9: `fwd_match` equals `match` from one cycle earlier, and `fwd_ctx` equals `parse_state` from one cycle earlier.
- R10: While reset is high, every output is cleared on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop | input | 1 | Start-of-packet pulse |
| match | input | 17 | Per-token match pulses |
| parse_state | output | 27 | One-hot current grammar position |
| fwd_match | output | 17 | Match bits delayed one cycle |
| fwd_ctx | output | 27 | Parse position active when the forwarded match arrived |
| msg_valid | output | 1 | Whole record accepted, held until next packet |

## Verification
All sixteen combinations of key word, name order, title and phone are driven as directed records. Because the state bits are checked after every token, this separates a wrong OR-convergence from a wrong skip link around an optional element. Random records then add idle gaps, which expose missing hold behaviour. Some random records also repeat one token at a random point, and these separate the error-clear path from acceptance. A string sent after card close, and a start pulse that coincides with a match, show that the valid flag is held and that start-of-packet takes priority.

// File: rtl/cardparse_pkg.sv
package cardparse_pkg;

    localparam int N_TOK = 17;
    localparam int N_ST  = 27;

    // token bit numbers
    localparam int TK_STR     = 0;
    localparam int TK_CARD_O  = 1;
    localparam int TK_CARD_C  = 2;
    localparam int TK_KEY_O   = 3;
    localparam int TK_KEY_C   = 4;
    localparam int TK_W_FIRST = 5;
    localparam int TK_W_LAST  = 6;
    localparam int TK_NAME_O  = 7;
    localparam int TK_NAME_C  = 8;
    localparam int TK_FIRST_O = 9;
    localparam int TK_FIRST_C = 10;
    localparam int TK_LAST_O  = 11;
    localparam int TK_LAST_C  = 12;
    localparam int TK_TITLE_O = 13;
    localparam int TK_TITLE_C = 14;
    localparam int TK_PHONE_O = 15;
    localparam int TK_PHONE_C = 16;

    localparam int ST_ENTRY  = 0;
    localparam int ST_CARD_C = N_ST - 1;

    typedef logic [N_ST-1:0]  st_vec_t;
    typedef logic [N_TOK-1:0] tok_vec_t;

    // token that loads each grammar position (-1: entry, loaded by sop only)
    function automatic int tok_of(input int s);
        case (s)
            1:                           return TK_CARD_O;
            2:                           return TK_KEY_O;
            3:                           return TK_W_FIRST;
            4:                           return TK_W_LAST;
            5:                           return TK_KEY_C;
            6:                           return TK_NAME_O;
            7, 16:                       return TK_FIRST_O;
            9, 18:                       return TK_FIRST_C;
            10, 13:                      return TK_LAST_O;
            12, 15:                      return TK_LAST_C;
            8, 11, 14, 17, 21, 24:       return TK_STR;
            19:                          return TK_NAME_C;
            20:                          return TK_TITLE_O;
            22:                          return TK_TITLE_C;
            23:                          return TK_PHONE_O;
            25:                          return TK_PHONE_C;
            26:                          return TK_CARD_C;
            default:                     return -1;
        endcase
    endfunction

    // positions whose FOLLOW set contains position s
    function automatic st_vec_t pred_of(input int s);
        st_vec_t m;
        m = '0;
        case (s)
            4:       m[2] = 1'b1;
            5:       begin m[3] = 1'b1; m[4] = 1'b1; end
            13:      m[6] = 1'b1;
            19:      begin m[12] = 1'b1; m[18] = 1'b1; end
            23:      begin m[19] = 1'b1; m[22] = 1'b1; end
            26:      begin m[19] = 1'b1; m[22] = 1'b1; m[25] = 1'b1; end
            0:       m = '0;
            default: m[s-1] = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/follow_net.sv
module follow_net #(
    parameter int NS = cardparse_pkg::N_ST
) (
    input  logic [NS-1:0] state,
    output logic [NS-1:0] enable
);
    for (genvar i = 0; i < NS; i++) begin : g_or
        localparam logic [NS-1:0] PRED = NS'(cardparse_pkg::pred_of(i));
        assign enable[i] = |(state & PRED);
    end
endmodule

// File: rtl/token_select.sv
module token_select #(
    parameter int NS = cardparse_pkg::N_ST,
    parameter int NT = cardparse_pkg::N_TOK
) (
    input  logic [NT-1:0] match,
    output logic [NS-1:0] hit
);
    for (genvar i = 0; i < NS; i++) begin : g_sel
        localparam int TK = cardparse_pkg::tok_of(i);
        if (TK < 0) begin : g_none
            assign hit[i] = 1'b0;
        end else begin : g_tap
            assign hit[i] = match[TK];
        end
    end
endmodule

// File: rtl/grammar_cell.sv
module grammar_cell #(
    parameter bit IS_ENTRY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sop,
    input  logic evt,
    input  logic enable,
    input  logic hit,
    output logic q
);
    logic load;
    assign load = enable & hit;

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (sop) q <= IS_ENTRY;
        else if (evt) q <= load;
    end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
    parameter int NS = cardparse_pkg::N_ST,
    parameter int NT = cardparse_pkg::N_TOK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sop,
    input  logic          close_fire,
    input  logic [NT-1:0] match,
    input  logic [NS-1:0] state,
    output logic [NT-1:0] fwd_match,
    output logic [NS-1:0] fwd_ctx,
    output logic          msg_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_match <= '0;
            fwd_ctx   <= '0;
            msg_valid <= 1'b0;
        end else begin
            fwd_match <= match;
            fwd_ctx   <= state;
            if (sop)             msg_valid <= 1'b0;
            else if (close_fire) msg_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/card_parse_tracker.sv
module card_parse_tracker (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           sop,
    input  logic [cardparse_pkg::N_TOK-1:0] match,
    output logic [cardparse_pkg::N_ST-1:0]  parse_state,
    output logic [cardparse_pkg::N_TOK-1:0] fwd_match,
    output logic [cardparse_pkg::N_ST-1:0]  fwd_ctx,
    output logic                           msg_valid
);
    import cardparse_pkg::*;

    localparam int NS = N_ST;
    localparam int NT = N_TOK;

    st_vec_t enable, hit;
    logic    evt, close_fire;

    assign evt        = |match;
    assign close_fire = ~sop & enable[ST_CARD_C] & hit[ST_CARD_C];

    follow_net #(.NS(NS)) u_follow (
        .state (parse_state),
        .enable(enable)
    );

    token_select #(.NS(NS), .NT(NT)) u_tsel (
        .match(match),
        .hit  (hit)
    );

    for (genvar i = 0; i < NS; i++) begin : g_cell
        grammar_cell #(.IS_ENTRY(i == ST_ENTRY)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .sop   (sop),
            .evt   (evt),
            .enable(enable[i]),
            .hit   (hit[i]),
            .q     (parse_state[i])
        );
    end

    out_stage #(.NS(NS), .NT(NT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .sop       (sop),
        .close_fire(close_fire),
        .match     (match),
        .state     (parse_state),
        .fwd_match (fwd_match),
        .fwd_ctx   (fwd_ctx),
        .msg_valid (msg_valid)
    );
endmodule

// File: rtl/card_parse_tracker_chk.sv
module card_parse_tracker_chk (
    input logic                            clk,
    input logic                            rst,
    input logic                            sop,
    input logic [cardparse_pkg::N_TOK-1:0] match,
    input logic [cardparse_pkg::N_ST-1:0]  parse_state,
    input logic [cardparse_pkg::N_TOK-1:0] fwd_match,
    input logic [cardparse_pkg::N_ST-1:0]  fwd_ctx,
    input logic                            msg_valid
);
    logic past_rst;
    always_ff @(posedge clk) past_rst <= rst;

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (parse_state == '0 && fwd_match == '0 && fwd_ctx == '0 && !msg_valid));

    assert_state_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(parse_state));

    assert_sop_entry_R1: assert property (@(posedge clk) disable iff (rst)
        sop |=> (parse_state == cardparse_pkg::N_ST'(1) && !msg_valid));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!sop && match == '0) |=> ($stable(parse_state) && $stable(msg_valid)));

    assert_dead_stays_R7: assert property (@(posedge clk) disable iff (rst)
        (!sop && parse_state == '0) |=> parse_state == '0);

    assert_valid_at_close_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> parse_state[cardparse_pkg::ST_CARD_C]);

    assert_valid_held_R8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !sop) |=> msg_valid);

    assert_forward_R9: assert property (@(posedge clk) disable iff (rst)
        !past_rst |-> (fwd_match == $past(match) && fwd_ctx == $past(parse_state)));
endmodule

bind card_parse_tracker card_parse_tracker_chk i_chk (
    .clk(clk), .rst(rst), .sop(sop), .match(match),
    .parse_state(parse_state), .fwd_match(fwd_match),
    .fwd_ctx(fwd_ctx), .msg_valid(msg_valid)
);

// File: tb/test_card_parse_tracker.sv
`timescale 1ns/1ps
module test_card_parse_tracker;
    localparam int NT = 17;
    localparam int NS = 27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sop = 1'b0;
    logic [NT-1:0] match = '0;
    logic [NS-1:0] parse_state, fwd_ctx;
    logic [NT-1:0] fwd_match;
    logic msg_valid;

    int n_chk = 0;
    int n_bad = 0;

    int toks [64];
    int occs [64];
    int nlen;

    always #2.5 clk = ~clk;

    card_parse_tracker i_card_parse_tracker (
        .clk(clk), .rst(rst), .sop(sop), .match(match),
        .parse_state(parse_state), .fwd_match(fwd_match),
        .fwd_ctx(fwd_ctx), .msg_valid(msg_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [NS-1:0] st_bit(input int o);
        logic [NS-1:0] v;
        v = '0;
        if (o >= 0) v[o] = 1'b1;
        return v;
    endfunction

    function automatic void add(input int t, input int o);
        toks[nlen] = t;
        occs[nlen] = o;
        nlen++;
    endfunction

    // build a token list with the expected position after each token (R4 numbering)
    function automatic void build(input bit key_last, input bit lf, input bit has_title, input bit has_phone);
        nlen = 0;
        add(1, 1); add(3, 2);
        if (key_last) add(6, 4); else add(5, 3);
        add(4, 5); add(7, 6);
        if (!lf) begin
            add(9, 7);  add(0, 8);  add(10, 9);
            add(11, 10); add(0, 11); add(12, 12);
        end else begin
            add(11, 13); add(0, 14); add(12, 15);
            add(9, 16);  add(0, 17); add(10, 18);
        end
        add(8, 19);
        if (has_title) begin add(13, 20); add(0, 21); add(14, 22); end
        if (has_phone) begin add(15, 23); add(0, 24); add(16, 25); end
        add(2, 26);
    endfunction

    task automatic start_pkt(input bool_with_match);
        logic [NS-1:0] prev;
        prev = parse_state;
        sop = 1'b1;
        if (bool_with_match) match[1] = 1'b1;
        @(negedge clk);
        sop = 1'b0;
        match = '0;
        chk(parse_state == st_bit(0), "R1 entry", 64'(parse_state), 64'(st_bit(0)));
        chk(!msg_valid, "R1 valid cleared", 64'(msg_valid), 64'd0);
    endtask

    task automatic send(input int t, input int o, input string req);
        logic [NS-1:0] prev;
        logic [NT-1:0] mexp;
        prev = parse_state;
        mexp = '0;
        mexp[t] = 1'b1;
        match = mexp;
        @(negedge clk);
        match = '0;
        chk(parse_state == st_bit(o), req, 64'(parse_state), 64'(st_bit(o)));
        chk(fwd_match == mexp && fwd_ctx == prev, "R9 forward", 64'(fwd_ctx), 64'(prev));
    endtask

    task automatic idle(input int n);
        logic [NS-1:0] hold;
        logic hv;
        hold = parse_state;
        hv = msg_valid;
        repeat (n) @(negedge clk);
        chk(parse_state == hold && msg_valid == hv, "R3 idle hold", 64'(parse_state), 64'(hold));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(parse_state == '0 && fwd_match == '0 && fwd_ctx == '0 && !msg_valid,
            "R10 reset", 64'(parse_state), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // directed: all sixteen record shapes (R4 key, R5 order, R6 optionals)
        for (int c = 0; c < 16; c++) begin
            build(c[0], c[1], c[2], c[3]);
            start_pkt(1'b0);
            for (int k = 0; k < nlen; k++) begin
                if (k == 2) send(toks[k], occs[k], "R4 route key");
                else if (k >= 5 && k <= 11) send(toks[k], occs[k], "R5 name order");
                else if (k > 11) send(toks[k], occs[k], "R6 optional tail");
                else send(toks[k], occs[k], "R3 advance");
            end
            chk(msg_valid, "R8 valid at close", 64'(msg_valid), 64'd1);
            send(0, -1, "R7 token after close");
            chk(msg_valid, "R8 valid held", 64'(msg_valid), 64'd1);
            idle(2);
        end

        // start pulse coinciding with a match (R1)
        start_pkt(1'b1);
        send(1, 1, "R3 after sop");
        // unexpected token clears (R7)
        send(1, -1, "R7 repeat clears");
        send(3, -1, "R7 dead stays");
        chk(!msg_valid, "R7 no valid", 64'(msg_valid), 64'd0);

        // random records with gaps and optional corruption
        for (int m = 0; m < 120; m++) begin
            int bad_at;
            bit dead;
            build($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
            bad_at = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, nlen - 1)) : -1;
            dead = 1'b0;
            start_pkt(1'b0);
            for (int k = 0; k < nlen; k++) begin
                if (k == bad_at) begin
                    send(toks[k-1], -1, "R7 repeated token");
                    dead = 1'b1;
                end
                send(toks[k], dead ? -1 : occs[k], dead ? "R7 dead stays" : "R3 random advance");
                if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
            end
            chk(msg_valid == !dead, "R8 random valid", 64'(msg_valid), 64'(!dead));
        end

        // truncated record: no card close, no valid (R8)
        build(1'b0, 1'b0, 1'b0, 1'b0);
        start_pkt(1'b0);
        for (int k = 0; k < nlen - 1; k++) send(toks[k], occs[k], "R3 truncated");
        chk(!msg_valid, "R8 truncated no valid", 64'(msg_valid), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule